// File: doc/BRIEF.md
# Sized Shift and Rotate Unit

This block performs one of four bit-movement operations on a destination operand of byte, word or long size. The operations are arithmetic shift left, arithmetic shift right, rotate left and rotate right. The count is a 4-bit quick constant from 0 to 15. Only the low 8, 16 or 32 bits selected by the size take part in the operation. Any bits above that field leave the block exactly as they arrived.

Besides the result, the block produces four condition flags. N is the sign of the sized result and Z is set when the sized result is zero. V is overflow and is set only by the left arithmetic shift. C is the carry: a single bit picked from the operand before the operation, at a position that depends on the count and on the operand width. A count of zero forces the carry to zero.

Operations enter through a valid/ready handshake, one per cycle. A barrel structure computes each one in a single cycle, and the result and flags are held in an output register. That register also uses valid/ready, so a stalled consumer holds the result in place and stops new input.

Top module: `shrot_unit`

## Requirements
- R1: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result and flags appear with `out_valid` high right after that edge. `in_ready` is high whenever the output register is empty or is being read in the same cycle.
- R2: While `out_valid` is high and `out_ready` is low, the result and flags stay unchanged and `in_ready` is low.
- R3: `in_op` encodes 00 = arithmetic shift left, 01 = arithmetic shift right, 10 = rotate left, 11 = rotate right. `in_size` encodes 00 = byte (bits 7:0), 01 = word (bits 15:0), 10 and 11 = long (bits 31:0). Bits of `in_data` above the sized field pass to `out_data` unchanged.
- R4: Arithmetic shift left moves the sized field left by the count and fills with zeros. For byte size, a count of 8 or more gives a zero field.
- R5: Arithmetic shift right moves the sized field right by the count and fills with copies of the original top bit of the field. For byte size, a count of 8 or more gives a field made entirely of that bit.
- R6: Rotate left and rotate right wrap within the sized field only, so the effective amount is the count modulo the field width.
- R7: With a count of zero, every operation returns the operand unchanged and C is 0.
- R8: For shift left and rotate left with a count r greater than 0, C is the original operand bit at index (w − r) mod w, where w is the field width.
- R9: For shift right and rotate right with a count r greater than 0, C is the original operand bit at index (r − 1) mod w.
- R10: For shift left, V is the original top bit of the field XOR the top bit of the result field. For the other three operations, V is 0.
- R11: N equals the top bit of the sized result field. Z is 1 exactly when the sized result field is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 2 | Operation select |
| in_size | input | 2 | Operand size select |
| in_cnt | input | CW (4) | Shift or rotate count |
| in_data | input | DW (32) | Destination operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DW (32) | Result with untouched upper bits |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
Some properties are checked by assertions on every cycle. These cover the handshake (ready when empty, and an output held steady under backpressure). They also cover the pass-through of bits above the size, the identity and cleared carry at count zero, a cleared V outside shift left, and preservation of the sign under shift right. The exact bit values of results and carries need the bench's scenarios. These include wrap-around rotates and byte counts of 8 to 15, where the carry index wraps modulo the width. The scenarios also cover word and long counts of 15 and the alternative long size code. The bench's behavioural model moves bits one step at a time and compares every delivered result against it.

// File: rtl/shr_pkg.sv
`timescale 1ns/1ps
package shr_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    OP_ASL = 2'b00,
    OP_ASR = 2'b01,
    OP_ROL = 2'b10,
    OP_ROR = 2'b11
  } shr_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } shr_flags_t;
endpackage

// File: rtl/shr_lane.sv
`timescale 1ns/1ps
// One fixed-width barrel lane: result and pre-shift carry bit.
module shr_lane import shr_pkg::*; #(
  parameter int W  = 8,
  parameter int CW = CNT_W
) (
  input  shr_op_e        op,
  input  logic [CW-1:0]  cnt,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic           cout
);
  localparam int KW = $clog2(W);

  logic [KW-1:0]  rot_k;    // count modulo W
  logic [KW-1:0]  up_idx;   // (W - r) mod W
  logic [KW-1:0]  dn_idx;   // (r - 1) mod W
  logic [2*W-1:0] rol_w;
  logic [2*W-1:0] ror_w;
  logic           cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign rot_k    = KW'(cnt);
  assign up_idx   = KW'(0) - rot_k;
  assign dn_idx   = KW'(cnt) - KW'(1);
  assign rol_w    = {din, din} << rot_k;
  assign ror_w    = {din, din} >> rot_k;

  always_comb begin
    unique case (op)
      OP_ASL:  dout = din << cnt;
      OP_ASR:  dout = $unsigned($signed(din) >>> cnt);
      OP_ROL:  dout = rol_w[2*W-1:W];
      default: dout = ror_w[W-1:0];
    endcase
  end

  always_comb begin
    if (cnt_zero)
      cout = 1'b0;
    else if (op == OP_ASL || op == OP_ROL)
      cout = din[up_idx];
    else
      cout = din[dn_idx];
  end
endmodule

// File: rtl/shr_flags.sv
`timescale 1ns/1ps
// Condition flag formation from sized result and operand sign.
module shr_flags import shr_pkg::*; (
  input  shr_op_e    op,
  input  logic       src_top,
  input  logic       res_top,
  input  logic       res_zero,
  input  logic       shift_c,
  output shr_flags_t flags
);
  always_comb begin
    flags.n = res_top;
    flags.z = res_zero;
    flags.v = (op == OP_ASL) ? (src_top ^ res_top) : 1'b0;
    flags.c = shift_c;
  end
endmodule

// File: rtl/shrot_unit.sv
`timescale 1ns/1ps
module shrot_unit import shr_pkg::*; #(
  parameter int DW = 32,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [CW-1:0] in_cnt,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_n,
  output logic          out_z,
  output logic          out_v,
  output logic          out_c
);
  localparam int NLANE = 3;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'b00:   return {{(DW-DW/4){1'b0}}, {(DW/4){1'b1}}};
      2'b01:   return {{(DW-DW/2){1'b0}}, {(DW/2){1'b1}}};
      default: return '1;
    endcase
  endfunction

  function automatic logic top_bit(input logic [DW-1:0] d, input logic [1:0] s);
    case (s)
      2'b00:   return d[DW/4-1];
      2'b01:   return d[DW/2-1];
      default: return d[DW-1];
    endcase
  endfunction

  // Named internal events
  logic          fire;
  shr_op_e       op_w;
  logic [DW-1:0] lane_res [NLANE];
  logic [NLANE-1:0] lane_c;
  logic [DW-1:0] sel_res;
  logic          sel_c;
  logic [DW-1:0] fld_mask;
  logic [DW-1:0] merged;
  logic          src_top, res_top, res_zero;
  shr_flags_t    flags_w;
  shr_flags_t    flags_q;

  assign op_w     = shr_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DW >> (NLANE - 1 - g);
    logic [LW-1:0] lane_out;
    shr_lane #(.W(LW), .CW(CW)) u_lane (
      .op   (op_w),
      .cnt  (in_cnt),
      .din  (in_data[LW-1:0]),
      .dout (lane_out),
      .cout (lane_c[g])
    );
    assign lane_res[g] = DW'(lane_out);
  end

  always_comb begin
    case (in_size)
      2'b00: begin sel_res = lane_res[0]; sel_c = lane_c[0]; end
      2'b01: begin sel_res = lane_res[1]; sel_c = lane_c[1]; end
      default: begin sel_res = lane_res[2]; sel_c = lane_c[2]; end
    endcase
  end

  assign fld_mask = size_mask(in_size);
  assign merged   = (in_data & ~fld_mask) | (sel_res & fld_mask);
  assign src_top  = top_bit(in_data, in_size);
  assign res_top  = top_bit(merged, in_size);
  assign res_zero = ((merged & fld_mask) == '0);

  shr_flags u_flags (
    .op       (op_w),
    .src_top  (src_top),
    .res_top  (res_top),
    .res_zero (res_zero),
    .shift_c  (sel_c),
    .flags    (flags_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      flags_q   <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= merged;
      flags_q   <= flags_w;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_n = flags_q.n;
  assign out_z = flags_q.z;
  assign out_v = flags_q.v;
  assign out_c = flags_q.c;

  // Assertions next to the output register
  p_ready_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(flags_q));

  p_upper_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((out_data ^ $past(in_data)) & ~size_mask($past(in_size))) == '0);

  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_cnt == '0 |=> out_data == $past(in_data) && !out_c);

  p_v_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_w != OP_ASL |=> !out_v);

  p_asr_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_w == OP_ASR |=>
      top_bit(out_data, $past(in_size)) == top_bit($past(in_data), $past(in_size)));
endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [1:0]  in_size;
  logic [3:0]  in_cnt;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_n, out_z, out_v, out_c;

  always #2.5 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_cnt(in_cnt), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
  );

  typedef struct {
    logic [1:0]  op;
    logic [1:0]  sz;
    int          cnt;
    logic [31:0] din;
  } stim_t;

  typedef struct {
    logic [1:0]  op;
    int          cnt;
    logic [31:0] din;
    logic [31:0] mask;
    logic [31:0] res;
    logic n, z, v, c;
  } exp_t;

  stim_t stim_q[$];
  exp_t  exp_q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Behavioural model: moves bits one position at a time.
  function automatic exp_t model(input stim_t s);
    exp_t e;
    int w, m;
    logic [31:0] r;
    logic b;
    w = (s.sz == 2'b00) ? 8 : (s.sz == 2'b01) ? 16 : 32;
    m = w - 1;
    e.mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    r = s.din & e.mask;
    for (int i = 0; i < s.cnt; i++) begin
      case (s.op)
        2'b00: r = (r << 1) & e.mask;
        2'b01: begin b = r[m]; r = r >> 1; r[m] = b; end
        2'b10: begin b = r[m]; r = ((r << 1) & e.mask); r[0] = b; end
        default: begin b = r[0]; r = r >> 1; r[m] = b; end
      endcase
    end
    if (s.cnt == 0) e.c = 1'b0;
    else if (s.op == 2'b00 || s.op == 2'b10) e.c = s.din[(((m - s.cnt + 1) % w) + w) % w];
    else e.c = s.din[(s.cnt - 1) % w];
    e.n   = r[m];
    e.z   = (r == 0);
    e.v   = (s.op == 2'b00) ? (s.din[m] ^ r[m]) : 1'b0;
    e.res = (s.din & ~e.mask) | r;
    e.op  = s.op;
    e.cnt = s.cnt;
    e.din = s.din;
    return e;
  endfunction

  task automatic add(input logic [1:0] op, input logic [1:0] sz, input int cnt,
                     input logic [31:0] d);
    stim_t s;
    s.op = op; s.sz = sz; s.cnt = cnt; s.din = d;
    stim_q.push_back(s);
  endtask

  function automatic string res_tag(input exp_t e);
    if (e.cnt == 0) return "R7";
    case (e.op)
      2'b00: return "R4";
      2'b01: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    stim_t cur;
    bit have;
    bit hold_prev;
    logic [31:0] hold_data;
    logic [3:0]  hold_flags;
    int cyc;
    bit acc, dlv;
    exp_t e;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_size = '0; in_cnt = '0; in_data = '0;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "reset out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "reset in_ready", 32'(in_ready), 1);
    check(out_data == 32'h0, "R1", "reset out_data", out_data, 0);
    rst_n = 1'b1;

    // Directed corner cases
    add(2'b00, 2'b00, 1, 32'hA5A5_C381);    // R4 R8 R10 sign change
    add(2'b01, 2'b00, 3, 32'h1234_5690);    // R5 negative byte
    add(2'b00, 2'b00, 8, 32'hFFFF_FF5A);    // R4 byte pushed out, R8 idx 0
    add(2'b00, 2'b00, 15, 32'h0000_0081);   // R8 wrapped index
    add(2'b01, 2'b00, 8, 32'h0000_0080);    // R5 all sign
    add(2'b01, 2'b00, 12, 32'hCAFE_0070);   // R9 wrapped index
    add(2'b10, 2'b00, 9, 32'h0000_00C3);    // R6 wrap modulo 8
    add(2'b11, 2'b00, 15, 32'h5500_0001);   // R6 R9
    add(2'b10, 2'b01, 15, 32'hDEAD_8001);   // R6 word
    add(2'b11, 2'b10, 15, 32'h8000_0001);   // R6 long
    add(2'b01, 2'b10, 15, 32'h8000_0000);   // R5 long
    add(2'b00, 2'b11, 4, 32'h0F00_0000);    // R3 alt long code, R10
    add(2'b01, 2'b01, 1, 32'h0000_0001);    // R11 zero result, R9
    for (int op = 0; op < 4; op++) add(2'(op), 2'b01, 0, 32'h9876_8000);  // R7
    for (int i = 0; i < 400; i++) add(2'($urandom), 2'($urandom), int'($urandom % 16), $urandom);

    have = 1'b0;
    hold_prev = 1'b0;
    hold_data = '0;
    hold_flags = '0;
    cyc = 0;
    while ((stim_q.size() > 0 || have || exp_q.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      // drive
      if (!have && stim_q.size() > 0 && ($urandom % 5 != 0)) begin
        cur = stim_q.pop_front();
        have = 1'b1;
      end
      in_valid = have;
      in_op = cur.op; in_size = cur.sz; in_cnt = 4'(cur.cnt); in_data = cur.din;
      out_ready = (cyc > 200 && cyc < 240) ? 1'b0 : ($urandom % 4 != 0);
      #1;
      // sample
      if (hold_prev) begin
        check(out_valid && out_data == hold_data, "R2", "held data", out_data, hold_data);
        check({out_n, out_z, out_v, out_c} == hold_flags, "R2", "held flags",
              32'({out_n, out_z, out_v, out_c}), 32'(hold_flags));
      end
      check(out_valid == (exp_q.size() > 0), "R1", "out_valid timing",
            32'(out_valid), 32'(exp_q.size() > 0));
      check(in_ready == (!out_valid || out_ready), "R1", "in_ready",
            32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R2", "ready low under stall", 32'(in_ready), 0);
      acc = in_valid && in_ready;
      dlv = out_valid && out_ready;
      if (dlv && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check((out_data & e.mask) == (e.res & e.mask), res_tag(e), "sized result",
              out_data, e.res);
        check((out_data & ~e.mask) == (e.din & ~e.mask), "R3", "upper bits",
              out_data, e.res);
        check(out_c == e.c, (e.cnt == 0) ? "R7" :
              (e.op == 2'b00 || e.op == 2'b10) ? "R8" : "R9", "carry",
              32'(out_c), 32'(e.c));
        check(out_v == e.v, "R10", "overflow", 32'(out_v), 32'(e.v));
        check(out_n == e.n && out_z == e.z, "R11", "N/Z",
              32'({out_n, out_z}), 32'({e.n, e.z}));
      end
      hold_prev  = out_valid && !out_ready;
      hold_data  = out_data;
      hold_flags = {out_n, out_z, out_v, out_c};
      if (acc) begin
        exp_q.push_back(model(cur));
        have = 1'b0;
      end
    end
    if (cyc >= 20000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 20000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule